// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the transfer bookkeeping for one direct-memory-access channel. Software programs it through a byte-wide write port with a start offset, a transfer count, an 8-bit page value and a mode byte. Once armed, the channel advances on every completed bus transfer reported by the transfer strobe. Each advance steps the 16-bit offset by one, up or down, and lowers the remaining count by one. The page byte sits above the offset to form a 24-bit physical address and never changes on its own, so the offset wraps inside its 64 KiB window.

When the count runs out, the channel flags terminal count during the final strobe. An external end-of-process input ends a transfer early in the same way. With auto-initialize off, the channel masks itself and ignores strobes until software arms it again. With auto-initialize on, the current offset and count are restored from the programmed base values and the same transfer runs again. Bus arbitration and the bus cycle timing are handled elsewhere.

Top module: `dma_chan_engine`

## Requirements
- R1: After synchronous reset, `phys_addr` is 0, `chan_active` is 0 (channel masked) and `tc_out` is 0.
- R2: Writes with `wr_sel`=0 load the start offset and writes with `wr_sel`=1 load the transfer count, low byte first and then high byte. A shared byte pointer toggles on each such write. Each byte goes into both the base register and the current register in the same cycle, so `phys_addr[15:0]` shows the new offset after the write.
- R3: A write with `wr_sel`=4 returns the byte pointer to the low byte. The data on that write is ignored.
- R4: With mode bit 0 clear, each `xfer_done` strobe while active adds one to `phys_addr[15:0]` in the cycle after the strobe.
- R5: With mode bit 0 set, each strobe while active subtracts one from `phys_addr[15:0]`. The mode is written with `wr_sel`=3: bit 0 selects downward stepping and bit 1 enables auto-initialize.
- R6: The offset wraps from 0xFFFF to 0x0000 going up and from 0x0000 to 0xFFFF going down. `phys_addr[23:16]` is never changed by a transfer.
- R7: `tc_out` is high for exactly the cycle of the strobe that brings the current count from 1 to 0, and only while `xfer_done` is high.
- R8: With auto-initialize off, `chan_active` drops in the cycle after terminal count. Strobes are then ignored: the address stays the same and no terminal count is raised. A write with `wr_sel`=5 arms the channel, and a write with `wr_sel`=6 masks it.
- R9: `eop_in` high while the channel is active ends the transfer like terminal count, with no `tc_out` pulse. `eop_in` has no effect while the channel is masked.
- R10: With auto-initialize on, terminal count or `eop_in` reloads the current offset and count from the base values and leaves the channel active.
- R11: A programmed count of 0 gives 65536 transfers, with terminal count on the 65536th strobe.
- R12: A write with `wr_sel`=2 sets `phys_addr[23:16]` to the written byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 offset byte, 1 count byte, 2 page, 3 mode, 4 clear byte pointer, 5 arm, 6 mask |
| wr_data | input | 8 | Write data byte |
| xfer_done | input | 1 | One completed bus transfer, one cycle per transfer |
| eop_in | input | 1 | External end of process |
| phys_addr | output | 24 | Page byte concatenated with the current 16-bit offset |
| tc_out | output | 1 | Terminal-count pulse, high during the final strobe |
| chan_active | output | 1 | Channel armed and not masked |

## Verification
The assertions assume that software does not write registers in the cycles where strobes or end-of-process arrive, apart from arming. A register write takes priority over a step, and several properties exclude cycles with `wr_en` high. They also assume that `xfer_done` is a single-cycle event per transfer. The bench keeps every programming sequence apart from strobe traffic, and it drives strobes and `eop_in` only on idle cycles of the write port. Strobes are issued one per cycle only in the long full-count run.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 2 * BYTE_W;
    localparam int PAGE_W = 8;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_OFS    = 3'd0,
        SEL_CNT    = 3'd1,
        SEL_PAGE   = 3'd2,
        SEL_MODE   = 3'd3,
        SEL_CLRPTR = 3'd4,
        SEL_ARM    = 3'd5,
        SEL_MASK   = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic autoinit;
        logic down;
    } mode_t;

    typedef struct packed {
        logic              ofs_wr;
        logic              cnt_wr;
        logic              hi;
        logic [BYTE_W-1:0] data;
    } byte_wr_t;

    function automatic logic [OFS_W-1:0] merge_byte(
        input logic [OFS_W-1:0]  old,
        input logic              hi,
        input logic [BYTE_W-1:0] b
    );
        return hi ? {b, old[BYTE_W-1:0]} : {old[OFS_W-1:BYTE_W], b};
    endfunction

    function automatic logic [OFS_W-1:0] step_ofs(
        input logic [OFS_W-1:0] a,
        input logic             down
    );
        return down ? a - OFS_W'(1) : a + OFS_W'(1);
    endfunction

endpackage

// File: rtl/dma_prog_port.sv
module dma_prog_port
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output byte_wr_t          bw,
    output logic [OFS_W-1:0]  base_ofs,
    output logic [OFS_W-1:0]  base_cnt,
    output logic [PAGE_W-1:0] page,
    output mode_t             mode,
    output logic              arm,
    output logic              disarm
);
    reg_sel_e sel;
    logic     ptr_hi;

    assign sel = reg_sel_e'(wr_sel);

    always_comb begin
        bw.ofs_wr = wr_en && (sel == SEL_OFS);
        bw.cnt_wr = wr_en && (sel == SEL_CNT);
        bw.hi     = ptr_hi;
        bw.data   = wr_data;
        arm       = wr_en && (sel == SEL_ARM);
        disarm    = wr_en && (sel == SEL_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_hi   <= 1'b0;
            base_ofs <= '0;
            base_cnt <= '0;
            page     <= '0;
            mode     <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_OFS: begin
                    base_ofs <= merge_byte(base_ofs, ptr_hi, wr_data);
                    ptr_hi   <= ~ptr_hi;
                end
                SEL_CNT: begin
                    base_cnt <= merge_byte(base_cnt, ptr_hi, wr_data);
                    ptr_hi   <= ~ptr_hi;
                end
                SEL_PAGE:   page   <= wr_data[PAGE_W-1:0];
                SEL_MODE:   mode   <= mode_t'(wr_data[1:0]);
                SEL_CLRPTR: ptr_hi <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dma_cur_regs.sv
module dma_cur_regs
    import dma_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  byte_wr_t         bw,
    input  logic [OFS_W-1:0] base_ofs,
    input  logic [OFS_W-1:0] base_cnt,
    input  logic             down,
    input  logic             step,
    input  logic             reload,
    output logic [OFS_W-1:0] cur_ofs,
    output logic             last
);
    logic [OFS_W-1:0] cur_cnt;

    assign last = (cur_cnt == OFS_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ofs <= '0;
            cur_cnt <= '0;
        end else begin
            if (bw.ofs_wr)   cur_ofs <= merge_byte(cur_ofs, bw.hi, bw.data);
            else if (reload) cur_ofs <= base_ofs;
            else if (step)   cur_ofs <= step_ofs(cur_ofs, down);

            if (bw.cnt_wr)   cur_cnt <= merge_byte(cur_cnt, bw.hi, bw.data);
            else if (reload) cur_cnt <= base_cnt;
            else if (step)   cur_cnt <= cur_cnt - OFS_W'(1);
        end
    end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic disarm,
    input  logic end_evt,
    input  logic autoinit,
    output logic masked
);
    always_ff @(posedge clk) begin
        if (rst)                       masked <= 1'b1;
        else if (disarm)               masked <= 1'b1;
        else if (arm)                  masked <= 1'b0;
        else if (end_evt && !autoinit) masked <= 1'b1;
    end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [BYTE_W-1:0]       wr_data,
    input  logic                    xfer_done,
    input  logic                    eop_in,
    output logic [PAGE_W+OFS_W-1:0] phys_addr,
    output logic                    tc_out,
    output logic                    chan_active
);
    byte_wr_t          bw;
    logic [OFS_W-1:0]  base_ofs, base_cnt, cur_ofs;
    logic [PAGE_W-1:0] page;
    mode_t             mode;
    logic              arm, disarm, masked, last;
    logic              step, end_evt, reload, autoinit_q;

    assign chan_active = !masked;
    assign step        = xfer_done && chan_active;
    assign tc_out      = step && last;
    assign end_evt     = tc_out || (eop_in && chan_active);
    assign reload      = end_evt && mode.autoinit;
    assign autoinit_q  = mode.autoinit;
    assign phys_addr   = {page, cur_ofs};

    dma_prog_port i_prog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bw(bw), .base_ofs(base_ofs), .base_cnt(base_cnt), .page(page),
        .mode(mode), .arm(arm), .disarm(disarm)
    );

    dma_cur_regs i_cur (
        .clk(clk), .rst(rst), .bw(bw), .base_ofs(base_ofs), .base_cnt(base_cnt),
        .down(mode.down), .step(step), .reload(reload),
        .cur_ofs(cur_ofs), .last(last)
    );

    dma_chan_ctrl i_ctrl (
        .clk(clk), .rst(rst), .arm(arm), .disarm(disarm), .end_evt(end_evt),
        .autoinit(mode.autoinit), .masked(masked)
    );
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic        xfer_done,
    input logic        eop_in,
    input logic [23:0] phys_addr,
    input logic        tc_out,
    input logic        chan_active,
    input logic        autoinit
);
    assert_tc_needs_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        tc_out |-> (xfer_done && chan_active));

    assert_stop_after_tc_R8: assert property (@(posedge clk) disable iff (rst)
        (tc_out && !autoinit && !wr_en) |=> !chan_active);

    assert_masked_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!chan_active && !wr_en) |=> $stable(phys_addr));

    assert_page_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == 3'd2) |=> (phys_addr[23:16] == $past(phys_addr[23:16])));

    assert_eop_ends_R9: assert property (@(posedge clk) disable iff (rst)
        (chan_active && eop_in && !autoinit && !wr_en) |=> !chan_active);

    assert_autoinit_stays_R10: assert property (@(posedge clk) disable iff (rst)
        (chan_active && (tc_out || eop_in) && autoinit && !wr_en) |=> chan_active);
endmodule

bind dma_chan_engine dma_chan_engine_chk i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .xfer_done(xfer_done),
    .eop_in(eop_in), .phys_addr(phys_addr), .tc_out(tc_out),
    .chan_active(chan_active), .autoinit(autoinit_q)
);

// File: tb/test_dma_chan_engine.sv
module test_dma_chan_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        xfer_done = 1'b0;
    logic        eop_in = 1'b0;
    logic [23:0] phys_addr;
    logic        tc_out;
    logic        chan_active;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_chan_engine i_dma_chan_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .xfer_done(xfer_done), .eop_in(eop_in), .phys_addr(phys_addr),
        .tc_out(tc_out), .chan_active(chan_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_ch(input logic [15:0] ofs, input logic [15:0] cnt,
                              input logic [7:0] pg, input logic [7:0] mode);
        wr(3'd6, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd0, ofs[7:0]);  wr(3'd0, ofs[15:8]);
        wr(3'd1, cnt[7:0]);  wr(3'd1, cnt[15:8]);
        wr(3'd2, pg);
        wr(3'd3, mode);
        wr(3'd5, 8'h00);
    endtask

    // one strobe; returns tc sampled while the strobe is high
    task automatic strobe(output logic tc_seen);
        @(negedge clk);
        xfer_done = 1'b1;
        #1 tc_seen = tc_out;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic eop_pulse();
        @(negedge clk);
        eop_in = 1'b1;
        #1 check("R9 no tc on eop", {31'd0, tc_out}, 32'd0);
        @(negedge clk);
        eop_in = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 addr", {8'd0, phys_addr}, 32'd0);
        check("R1 active", {31'd0, chan_active}, 32'd0);
        check("R1 tc", {31'd0, tc_out}, 32'd0);
    endtask

    task automatic t_up_and_stop();
        logic tc;
        program_ch(16'h1234, 16'd3, 8'h5A, 8'h00);
        check("R2 R12 programmed addr", {8'd0, phys_addr}, 32'h5A1234);
        check("R8 armed", {31'd0, chan_active}, 32'd1);
        strobe(tc);
        check("R7 no early tc", {31'd0, tc}, 32'd0);
        check("R4 step up", {8'd0, phys_addr}, 32'h5A1235);
        strobe(tc);
        check("R4 step up 2", {8'd0, phys_addr}, 32'h5A1236);
        strobe(tc);
        check("R7 tc on last", {31'd0, tc}, 32'd1);
        check("R4 step up 3", {8'd0, phys_addr}, 32'h5A1237);
        check("R8 masked after tc", {31'd0, chan_active}, 32'd0);
        check("R7 tc one cycle", {31'd0, tc_out}, 32'd0);
        strobe(tc);
        check("R8 ignored strobe tc", {31'd0, tc}, 32'd0);
        check("R8 ignored strobe addr", {8'd0, phys_addr}, 32'h5A1237);
        wr(3'd5, 8'h00);
        check("R8 rearm", {31'd0, chan_active}, 32'd1);
        wr(3'd6, 8'h00);
        check("R8 mask cmd", {31'd0, chan_active}, 32'd0);
    endtask

    task automatic t_ptr_clear();
        wr(3'd4, 8'h00);
        wr(3'd0, 8'hAA);
        wr(3'd4, 8'hFF);
        wr(3'd0, 8'h11);
        wr(3'd0, 8'h22);
        check("R3 pointer cleared", {16'd0, phys_addr[15:0]}, 32'h2211);
    endtask

    task automatic t_down_wrap();
        logic tc;
        program_ch(16'h0001, 16'd3, 8'h07, 8'h01);
        strobe(tc);
        check("R5 step down", {8'd0, phys_addr}, 32'h070000);
        strobe(tc);
        check("R6 down wrap page kept", {8'd0, phys_addr}, 32'h07FFFF);
        strobe(tc);
        check("R5 down tc", {31'd0, tc}, 32'd1);
        check("R5 down final", {8'd0, phys_addr}, 32'h07FFFE);
    endtask

    task automatic t_up_wrap();
        logic tc;
        program_ch(16'hFFFF, 16'd2, 8'h33, 8'h00);
        strobe(tc);
        check("R6 up wrap page kept", {8'd0, phys_addr}, 32'h330000);
    endtask

    task automatic t_eop();
        logic tc;
        program_ch(16'h4000, 16'd10, 8'h02, 8'h00);
        strobe(tc);
        eop_pulse();
        check("R9 eop masks", {31'd0, chan_active}, 32'd0);
        check("R9 addr after eop", {8'd0, phys_addr}, 32'h024001);
        eop_pulse();
        check("R9 eop when masked", {8'd0, phys_addr}, 32'h024001);
        check("R9 still masked", {31'd0, chan_active}, 32'd0);
    endtask

    task automatic t_autoinit();
        logic tc;
        program_ch(16'h0100, 16'd2, 8'h09, 8'h02);
        strobe(tc);
        strobe(tc);
        check("R10 tc", {31'd0, tc}, 32'd1);
        check("R10 addr reloaded", {8'd0, phys_addr}, 32'h090100);
        check("R10 stays active", {31'd0, chan_active}, 32'd1);
        strobe(tc);
        check("R10 restart step", {8'd0, phys_addr}, 32'h090101);
        strobe(tc);
        check("R10 count reloaded", {31'd0, tc}, 32'd1);
        strobe(tc);
        eop_pulse();
        check("R10 eop reload", {8'd0, phys_addr}, 32'h090100);
        check("R10 eop active", {31'd0, chan_active}, 32'd1);
    endtask

    task automatic t_count_zero();
        int tc_hits = 0;
        int tc_at = -1;
        program_ch(16'h0000, 16'h0000, 8'h01, 8'h00);
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            xfer_done = 1'b1;
            #1;
            if (tc_out) begin
                tc_hits++;
                tc_at = i;
            end
        end
        @(negedge clk);
        xfer_done = 1'b0;
        check("R11 single tc", tc_hits, 32'd1);
        check("R11 tc on 65536th", tc_at, 32'd65535);
        check("R11 wrapped addr", {8'd0, phys_addr}, 32'h010000);
        check("R11 masked", {31'd0, chan_active}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_up_and_stop();
        t_ptr_clear();
        t_down_wrap();
        t_up_wrap();
        t_eop();
        t_autoinit();
        t_count_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule